// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block sits between a simple request port and a single-data-rate SDRAM device. A client holds a request (bank, row, column, read or write) until the sequencer acknowledges it; the sequencer turns it into the device commands it needs (opening a row, closing a row that is in the way, then the column access) and drives them on a registered command bus of clock enable, four active-low strobes, bank address and thirteen address lines. Every output changes on the rising clock edge and the device samples it on the next one.

After reset the sequencer closes all banks and programs the mode register for sequential bursts of eight words, so one column command moves a 64-byte line over a 64-bit path. It keeps an open/idle flag and an open row for each of the four banks, and a single down-counter that holds back the next non-NOP command until the row-to-column, precharge, refresh, mode-load or burst time has passed. A free-running interval timer raises refresh requests; these win over client requests, and the sequencer closes every open bank before it issues AUTO REFRESH.

The clock enable pin follows a client input one cycle late. Because the device acts on a low clock enable one cycle after it samples it, the sequencer treats the cycle after a low clock enable as stopped: it sends NOP there and its delay counter does not move.

Top module: `sdr_cmd_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the command strobes {CS_n,RAS_n,CAS_n,WE_n} read 0111 (NOP), clock enable is high and the acknowledge is low.
- R2: The first two non-NOP commands after reset are PRECHARGE with A10=1 (all banks) and, at least tRP decoded cycles later, LOAD MODE with bank address 0, A12..A10 = 0 and A9..A0 = {3'b000, CAS latency[2:0], 1'b0 (sequential), 3'b011 (eight-word burst)}; no other command comes before them.
- R3: Commands are encoded on {CS_n,RAS_n,CAS_n,WE_n} as NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000; no other code is ever driven.
- R4: LOAD MODE is issued only when all banks are idle, and no non-NOP command follows it within tMRD decoded cycles.
- R5: ACTIVE goes only to an idle bank; READ or WRITE goes only to an open bank and at least tRCD decoded cycles after the ACTIVE that opened it.
- R6: A request whose row is open in its bank is served directly by READ or WRITE; if another row is open, that bank gets PRECHARGE with A10=0, then ACTIVE of the new row at least tRP decoded cycles later. ACTIVE drives the row on A12..A0; READ/WRITE drive column bits 9..0 on A9..A0, column bit 10 on A11, with A10 and A12 low.
- R7: No command other than NOP is issued within eight decoded cycles after a READ or WRITE, so the burst completes.
- R8: A refresh request is raised every REF_INT cycles and takes priority over client requests: open banks are closed by PRECHARGE with A10=1, AUTO REFRESH follows at least tRP decoded cycles later with all banks idle, and no non-NOP command follows within tRFC = tRCD + tRP decoded cycles.
- R9: The clock enable output equals the clock enable request of the previous cycle; a cycle that follows a cycle with low clock enable carries NOP, and such cycles count toward none of the delays.
- R10: The acknowledge is high for exactly the cycle that carries the READ (request write=0) or WRITE (write=1) serving the held request, and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_req | input | 1 | Requested clock enable level |
| req_valid | input | 1 | Request held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 11 | Target column (start of burst) |
| req_ack | output | 1 | Request served this cycle |
| sd_cke | output | 1 | Device clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Address lines A12..A0 |

## Verification
On every cycle the assertions check the bank-state rules: mode load and refresh only with every bank idle, ACTIVE only on an idle bank, column commands only on an open bank, NOP after a low clock enable, a quiet cycle after ACTIVE, and that the acknowledge only rides with a column command. Whether the delays are counted in decoded cycles only, whether a row miss closes exactly the right bank, the boot order and mode word, the column bit placement, and the refresh period and priority under steady traffic can only be shown by the bench's scenarios, with its own bank model following the command stream.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  localparam int NB        = 4;
  localparam int BA_W      = 2;
  localparam int ROW_W     = 13;
  localparam int COL_W     = 11;
  localparam int ADDR_W    = 13;
  localparam int BURST_LEN = 8;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_BOOT_PRE,
    ST_BOOT_MODE,
    ST_RUN
  } seq_state_e;

  localparam logic [ADDR_W-1:0] ADDR_ALL_BANKS = ADDR_W'(1 << 10);

  // Mode word: write burst mode 0, CAS latency, sequential, burst of eight
  function automatic logic [ADDR_W-1:0] mode_addr(input int cl);
    logic [9:0] m;
    m = {3'b000, 3'(cl), 1'b0, 3'b011};
    return {3'b000, m};
  endfunction

  // Column placement: A10 reserved (no auto precharge), bit 10 moves to A11
  function automatic logic [ADDR_W-1:0] col_addr(input logic [COL_W-1:0] c);
    return {1'b0, c[10], 1'b0, c[9:0]};
  endfunction
endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          hold,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (!hold && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R9: a stopped cycle leaves the delay untouched
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/sdr_bank_table.sv
module sdr_bank_table import sdr_seq_pkg::*; #(
  parameter int N  = NB,
  parameter int BW = BA_W,
  parameter int RW = ROW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_en,
  input  logic          pre_one,
  input  logic          pre_all,
  input  logic [BW-1:0] bank,
  input  logic [RW-1:0] row_in,
  output logic [N-1:0]  open_vec,
  output logic [RW-1:0] open_row
);
  logic [RW-1:0] rows [N];

  for (genvar i = 0; i < N; i++) begin : g_bank
    logic sel;
    assign sel = (bank == BW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_vec[i] <= 1'b0;
        rows[i]     <= '0;
      end else if (act_en && sel) begin
        open_vec[i] <= 1'b1;
        rows[i]     <= row_in;
      end else if (pre_all || (pre_one && sel)) begin
        open_vec[i] <= 1'b0;
      end
    end
  end

  assign open_row = rows[bank];

  assert_act_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |-> !open_vec[bank]);
endmodule

// File: rtl/sdr_cmd_seq.sv
module sdr_cmd_seq import sdr_seq_pkg::*; #(
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_MRD   = 2,
  parameter int CAS_LAT = 3,
  parameter int REF_INT = 780
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_req,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ack,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  localparam int T_RFC = T_RCD + T_RP;
  localparam int MAX_A = (T_RFC > BURST_LEN) ? T_RFC : BURST_LEN;
  localparam int MAXD  = (MAX_A > T_MRD) ? MAX_A : T_MRD;
  localparam int TW    = $clog2(MAXD + 1);
  localparam logic [TW-1:0] LD_RCD = TW'(T_RCD - 1);
  localparam logic [TW-1:0] LD_RP  = TW'(T_RP - 1);
  localparam logic [TW-1:0] LD_RFC = TW'(T_RFC - 1);
  localparam logic [TW-1:0] LD_MRD = TW'(T_MRD - 1);
  localparam logic [TW-1:0] LD_BL  = TW'(BURST_LEN - 1);

  seq_state_e          state_q, state_d;
  sdr_cmd_e            cmd_q, cmd_d;
  logic [BA_W-1:0]     ba_d;
  logic [ADDR_W-1:0]   addr_d;
  logic                ack_d;
  logic                ref_tick, ref_pend_q, ref_clr;
  logic                tmr_zero, tmr_load;
  logic [TW-1:0]       tmr_val;
  logic                act_en, pre_one, pre_all;
  logic [NB-1:0]       open_vec;
  logic [ROW_W-1:0]    open_row;
  logic                frozen, row_hit, iss_mode, iss_ref;

  assign frozen  = ~sd_cke;
  assign row_hit = open_vec[req_bank] && (open_row == req_row);

  sdr_refresh_timer #(.INTERVAL(REF_INT)) u_rtmr (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick));

  sdr_wait_timer #(.TW(TW)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .hold(frozen), .zero(tmr_zero));

  sdr_bank_table u_banks (
    .clk(clk), .rst_n(rst_n), .act_en(act_en), .pre_one(pre_one),
    .pre_all(pre_all), .bank(req_bank), .row_in(req_row),
    .open_vec(open_vec), .open_row(open_row));

  always_comb begin
    state_d  = state_q;
    cmd_d    = CMD_NOP;
    ba_d     = '0;
    addr_d   = '0;
    ack_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    act_en   = 1'b0;
    pre_one  = 1'b0;
    pre_all  = 1'b0;
    ref_clr  = 1'b0;
    if (!frozen && tmr_zero) begin
      unique case (state_q)
        ST_BOOT_PRE: begin
          cmd_d = CMD_PRE; addr_d = ADDR_ALL_BANKS; pre_all = 1'b1;
          tmr_load = 1'b1; tmr_val = LD_RP; state_d = ST_BOOT_MODE;
        end
        ST_BOOT_MODE: begin
          cmd_d = CMD_MRS; addr_d = mode_addr(CAS_LAT);
          tmr_load = 1'b1; tmr_val = LD_MRD; state_d = ST_RUN;
        end
        default: begin
          if (ref_pend_q) begin
            if (|open_vec) begin
              cmd_d = CMD_PRE; addr_d = ADDR_ALL_BANKS; pre_all = 1'b1;
              tmr_load = 1'b1; tmr_val = LD_RP;
            end else begin
              cmd_d = CMD_REF; ref_clr = 1'b1;
              tmr_load = 1'b1; tmr_val = LD_RFC;
            end
          end else if (req_valid) begin
            ba_d = req_bank;
            if (row_hit) begin
              cmd_d = req_write ? CMD_WR : CMD_RD; addr_d = col_addr(req_col);
              ack_d = 1'b1; tmr_load = 1'b1; tmr_val = LD_BL;
            end else if (open_vec[req_bank]) begin
              cmd_d = CMD_PRE; pre_one = 1'b1;
              tmr_load = 1'b1; tmr_val = LD_RP;
            end else begin
              cmd_d = CMD_ACT; addr_d = req_row; act_en = 1'b1;
              tmr_load = 1'b1; tmr_val = LD_RCD;
            end
          end
        end
      endcase
    end
  end

  assign iss_mode = (cmd_d == CMD_MRS);
  assign iss_ref  = (cmd_d == CMD_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_BOOT_PRE;
      cmd_q      <= CMD_NOP;
      sd_ba      <= '0;
      sd_addr    <= '0;
      req_ack    <= 1'b0;
      sd_cke     <= 1'b1;
      ref_pend_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cmd_q      <= cmd_d;
      sd_ba      <= ba_d;
      sd_addr    <= addr_d;
      req_ack    <= ack_d;
      sd_cke     <= cke_req;
      ref_pend_q <= ref_tick | (ref_pend_q & ~ref_clr);
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  assert_mode_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_mode |-> (open_vec == '0));
  assert_ref_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iss_ref |-> (open_vec == '0));
  assert_rw_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> open_vec[sd_ba]);
  assert_act_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RCD > 1 && cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP));
  assert_freeze_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cke |=> (cmd_q == CMD_NOP));
  assert_ack_col_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (cmd_q == CMD_RD || cmd_q == CMD_WR));
endmodule

// File: tb/sim_sdr_cmd_seq.sv
module sim_sdr_cmd_seq;
  localparam int CLK_P   = 10;
  localparam int T_RCD   = 3;
  localparam int T_RP    = 3;
  localparam int T_MRD   = 2;
  localparam int CAS_LAT = 3;
  localparam int REF_INT = 780;
  localparam int T_RFC   = T_RCD + T_RP;
  localparam int BL      = 8;

  logic clk = 0, rst_n = 0, cke_req = 1;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_bank = 0;
  logic [12:0] req_row = 0;
  logic [10:0] req_col = 0;
  logic req_ack, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [12:0] sd_addr;

  sdr_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_MRD(T_MRD), .CAS_LAT(CAS_LAT),
                .REF_INT(REF_INT)) u0 (
    .clk(clk), .rst_n(rst_n), .cke_req(cke_req), .req_valid(req_valid),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_ack(req_ack), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr));

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0, done = 0;
  // bench model of the device
  bit bank_open [4];
  int bank_row [4];
  int since_act [4];
  int since_pre [4];
  int since_mrs = 1000, since_ref = 1000, since_rw = 1000;
  int boot_stage = 0, expect_ref = 0, served = 0, ref_count = 0;
  int win = 0, last_ref_win = -1, cke_low_seen = 0;
  bit prev_cke = 1, prev_cke_req = 1;
  // request currently held by the driver
  bit cur_valid = 0, cur_wr = 0;
  int cur_bank = 0, cur_row = 0, cur_col = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_col_addr(input int c);
    return (((c >> 10) & 1) << 11) | (c & 'h3ff);
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) begin
      bank_open[i] = 0; bank_row[i] = 0; since_act[i] = 1000; since_pre[i] = 1000;
    end
  end

  // command-stream monitor, sampled mid-cycle
  always @(negedge clk) begin : mon
    int c, b, a, min_pre;
    if (rst_n) begin
      win++;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      b = sd_ba;
      a = sd_addr;
      chk(sd_cke == prev_cke_req, "R9", "cke follows request", sd_cke, prev_cke_req);
      if (!sd_cke) cke_low_seen = 1;
      if (!(c == 4'b0101 || c == 4'b0100))
        chk(req_ack == 0, "R10", "ack without column cmd", req_ack, 0);
      if (!prev_cke) begin
        chk(c == 4'b0111, "R9", "cmd after low cke", c, 7);
      end else begin
        for (int i = 0; i < 4; i++) begin since_act[i]++; since_pre[i]++; end
        since_mrs++; since_ref++; since_rw++;
        if (c != 4'b0111) begin
          chk(since_mrs >= T_MRD, "R4", "gap after mode load", since_mrs, T_MRD);
          chk(since_ref >= T_RFC, "R8", "gap after refresh", since_ref, T_RFC);
          chk(since_rw >= BL, "R7", "gap after burst", since_rw, BL);
          min_pre = 1000;
          for (int i = 0; i < 4; i++) if (since_pre[i] < min_pre) min_pre = since_pre[i];
          case (c)
            4'b0010: begin
              if (boot_stage == 0) begin
                chk((a >> 10) & 1, "R2", "boot precharge A10", (a >> 10) & 1, 1);
                boot_stage = 1;
                for (int i = 0; i < 4; i++) begin bank_open[i] = 0; since_pre[i] = 0; end
              end else if ((a >> 10) & 1) begin
                chk(boot_stage == 2, "R2", "precharge-all during boot", boot_stage, 2);
                expect_ref = 1;
                for (int i = 0; i < 4; i++) begin bank_open[i] = 0; since_pre[i] = 0; end
              end else begin
                chk(cur_valid && b == cur_bank && bank_open[b] && bank_row[b] != cur_row,
                    "R6", "single precharge only on row miss", b, cur_bank);
                chk(expect_ref == 0, "R8", "user cmd before refresh", c, 1);
                bank_open[b] = 0; since_pre[b] = 0;
              end
            end
            4'b0000: begin
              chk(boot_stage == 1, "R2", "mode load order", boot_stage, 1);
              chk(a == ((CAS_LAT << 4) | 3), "R2", "mode word", a, (CAS_LAT << 4) | 3);
              chk(b == 0, "R2", "mode load bank addr", b, 0);
              chk(!(bank_open[0] | bank_open[1] | bank_open[2] | bank_open[3]),
                  "R4", "mode load with open bank", 1, 0);
              chk(min_pre >= T_RP, "R2", "precharge to mode load", min_pre, T_RP);
              boot_stage = 2; since_mrs = 0;
            end
            4'b0001: begin
              chk(boot_stage == 2, "R2", "refresh during boot", boot_stage, 2);
              chk(!(bank_open[0] | bank_open[1] | bank_open[2] | bank_open[3]),
                  "R8", "refresh with open bank", 1, 0);
              chk(min_pre >= T_RP, "R8", "precharge to refresh", min_pre, T_RP);
              if (last_ref_win >= 0 && !cke_low_seen)
                chk(win - last_ref_win >= REF_INT - 20 && win - last_ref_win <= REF_INT + 20,
                    "R8", "refresh period", win - last_ref_win, REF_INT);
              last_ref_win = win; cke_low_seen = 0;
              since_ref = 0; expect_ref = 0; ref_count++;
            end
            4'b0011: begin
              chk(boot_stage == 2, "R2", "activate during boot", boot_stage, 2);
              chk(!bank_open[b], "R5", "activate on open bank", bank_open[b], 0);
              chk(since_pre[b] >= T_RP, "R6", "precharge to activate", since_pre[b], T_RP);
              chk(cur_valid && b == cur_bank && a == cur_row, "R6", "activate row", a, cur_row);
              chk(expect_ref == 0, "R8", "user cmd before refresh", c, 1);
              bank_open[b] = 1; bank_row[b] = a; since_act[b] = 0;
            end
            4'b0101, 4'b0100: begin
              chk(boot_stage == 2, "R2", "access during boot", boot_stage, 2);
              chk(bank_open[b] && bank_row[b] == cur_row, "R5", "access on open matching row",
                  bank_row[b], cur_row);
              chk(since_act[b] >= T_RCD, "R5", "activate to access", since_act[b], T_RCD);
              chk(cur_valid && b == cur_bank, "R10", "access bank", b, cur_bank);
              chk(a == exp_col_addr(cur_col), "R6", "column placement", a, exp_col_addr(cur_col));
              chk((c == 4'b0100) == cur_wr, "R10", "direction", c, cur_wr ? 4 : 5);
              chk(req_ack == 1, "R10", "ack with access", req_ack, 1);
              chk(expect_ref == 0, "R8", "user cmd before refresh", c, 1);
              since_rw = 0; cur_valid = 0; served++;
            end
            default: chk(0, "R3", "illegal command code", c, 7);
          endcase
        end
      end
      prev_cke = sd_cke;
    end
    prev_cke_req = cke_req;
  end

  task automatic do_req(input bit wr, input int b, input int r, input int c);
    int start;
    @(posedge clk); #1;
    cur_bank = b; cur_row = r; cur_col = c; cur_wr = wr; cur_valid = 1;
    req_write = wr; req_bank = 2'(b); req_row = 13'(r); req_col = 11'(c);
    req_valid = 1;
    start = served;
    wait (served != start);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic stop_clock(input int n);
    @(posedge clk); #1; cke_req = 0;
    repeat (n) @(posedge clk);
    #1; cke_req = 1;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "reset cmd",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7);
    chk(sd_cke == 1, "R1", "reset cke", sd_cke, 1);
    chk(req_ack == 0, "R1", "reset ack", req_ack, 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "first cycle cmd",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7);
    wait (boot_stage == 2);
    // miss on idle bank, then hit, then row miss
    do_req(1, 0, 5, 'h123);
    do_req(0, 0, 5, 'h7ff);
    do_req(0, 0, 9, 'h400);
    do_req(1, 3, 8191, 'h001);
    do_req(0, 3, 8191, 'h3ff);
    // clock stopped while a request waits
    fork
      do_req(1, 2, 77, 'h055);
      begin repeat (2) @(posedge clk); stop_clock(6); end
    join
    stop_clock(3);
    do_req(0, 2, 77, 'h056);
    // mixed traffic across banks and rows
    for (int i = 0; i < 40; i++)
      do_req(i % 3 == 0, (i * 3) % 4, (i * 7) % 5, (i * 131) % 2048);
    repeat (2600) @(posedge clk);
    @(negedge clk);
    chk(served == 47, "R10", "requests served", served, 47);
    base = win / REF_INT - 1;
    chk(ref_count >= base, "R8", "refresh count", ref_count, base);
    chk(boot_stage == 2, "R2", "boot finished", boot_stage, 2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule